// File: doc/BRIEF.md
# Flash Status Auto-Polling Matcher

This block keeps reading the status of a serial flash device without software help. Once started in polling mode, it sends a status-read opcode on a single data line and clocks in two status bytes. It then compares the masked status with a programmable match value, releases chip select for a programmable interval, and starts over. A successful comparison sets a sticky match flag. The flag can drive an interrupt output.

Software picks one of two ways to end polling. With automatic stop set, the engine halts on its own at the first match. With it clear, polling runs until an abort request. A cleared flag is set again by any later match. The serial clock runs at half the system clock. The device under poll drives its data on the falling SCK edge, and the block samples it on the rising edge.

Top module: `flash_status_poller`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `csN` is 1, `sck` is 0, `mosi` is 0, and `matchFlag` and `irq` are 0.
- R2: A `launch` pulse starts polling only when `cfgMode` is 2'b10. A pulse with any other mode value, or a pulse while `busy` is 1, is ignored.
- R3: Each poll frame holds `csN` low for 24 SCK periods, with SCK at system clock / 2. SCK is low in the first system cycle of each period and high in the second. During the first 8 periods, `mosi` carries `cfgOpcode` most significant bit first.
- R4: The 16 status bits clocked in on `miso` are assembled as follows. The first byte received goes to bits [7:0] and the second to bits [15:8], each byte most significant bit first. The result appears on `statusWord` at the end of every completed frame.
- R5: A frame is a match when (status AND `cfgMask`) equals (`cfgMatch` AND `cfgMask`). A match sets `matchFlag` one clock after the last SCK period of the frame. A mismatch leaves the flag unchanged.
- R6: A one-cycle pulse on `clrStatusMatch` clears `matchFlag`. When a match lands in the same cycle, the set wins.
- R7: `irq` is high exactly while `matchFlag` and `cfgIntEn` are both 1.
- R8: With `cfgAutoStop` at 1, a matching frame ends polling: `busy` falls together with the flag rising, and no further frame starts.
- R9: With `cfgAutoStop` at 0, polling continues after a match. A flag cleared by software is set again by the next matching frame.
- R10: Between frames `csN` stays high for 2*N system cycles, where N is `cfgInterval` (sampled at the end of the frame), or 1 when `cfgInterval` is 0.
- R11: An `abortReq` pulse raises `abortPending` for exactly the next cycle. At the clock edge that ends that cycle, polling stops: `busy` falls, `csN` goes high, and the interrupted frame does not update the flag or `statusWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | Functional mode; 2'b10 selects status polling |
| launch | input | 1 | Start pulse |
| cfgOpcode | input | 8 | Status-read opcode sent at the start of each frame |
| cfgMask | input | 16 | Bits of the status that take part in the compare |
| cfgMatch | input | 16 | Expected value of the masked status bits |
| cfgIntEn | input | 1 | Match interrupt enable |
| cfgAutoStop | input | 1 | Halt polling at the first match |
| cfgInterval | input | 16 | Chip-select-high time between frames, in SCK periods |
| abortReq | input | 1 | Abort pulse |
| clrStatusMatch | input | 1 | Clear pulse for the match flag |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | Polling in progress |
| abortPending | output | 1 | Abort in progress, clears itself |
| matchFlag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |
| statusWord | output | 16 | Status assembled in the last completed frame |

## Verification
The hardest situation to reach is a match on a later frame of a free-running poll. This involves mismatching frames first, then a match, then a software clear, then another match, all while chip select keeps toggling with the programmed gap. The bench's flash model serves a status word that the stimulus rewrites only while chip select is high between frames. This lets one launch move from a mismatch to a match without disturbing a frame. A behavioural position-in-period model predicts every pin on every clock, so gap length, abort timing and flag re-set are all checked at cycle accuracy.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam logic [1:0] MODE_POLL = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_STAT = 2'd2,
    ST_GAP  = 2'd3
  } pollState_t;

  typedef struct packed {
    logic loadCmd;
    logic shiftCmd;
    logic sampleBit;
    logic compare;
  } pollStrb_t;

endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int STAT_BITS = 16,
  parameter int GAP_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic             launch,
  input  logic             cfgAutoStop,
  input  logic [GAP_W-1:0] cfgInterval,
  input  logic             abortReq,
  input  logic             hit,
  output pollStrb_t        strb,
  output logic             inCmd,
  output logic             busy,
  output logic             csN,
  output logic             sck,
  output logic             abortPending
);

  localparam int MAXB  = (CMD_BITS > STAT_BITS) ? CMD_BITS : STAT_BITS;
  localparam int CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STAT_BITS - 1);

  pollState_t       state;
  logic             phase;
  logic [CNT_W-1:0] bitCnt;
  logic [GAP_W:0]   gapCnt;
  logic             abortPend;

  logic [GAP_W-1:0] ivl;
  logic [GAP_W:0]   gapLoad;
  logic             startOk;
  logic             shifting;

  assign ivl      = (cfgInterval == '0) ? GAP_W'(1) : cfgInterval;
  assign gapLoad  = {ivl, 1'b0} - (GAP_W + 1)'(1);
  assign startOk  = launch && (cfgMode == MODE_POLL);
  assign shifting = (state == ST_CMD) || (state == ST_STAT);

  always_comb begin
    strb.loadCmd   = !abortPend && (((state == ST_IDLE) && startOk) ||
                                    ((state == ST_GAP) && (gapCnt == '0)));
    strb.shiftCmd  = (state == ST_CMD) && phase;
    strb.sampleBit = (state == ST_STAT) && !phase;
    strb.compare   = !abortPend && (state == ST_STAT) && phase && (bitCnt == STAT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      bitCnt    <= '0;
      gapCnt    <= '0;
      abortPend <= 1'b0;
    end else begin
      abortPend <= abortReq;
      if (abortPend) begin
        state  <= ST_IDLE;
        phase  <= 1'b0;
        bitCnt <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (startOk) begin
              state  <= ST_CMD;
              phase  <= 1'b0;
              bitCnt <= '0;
            end
          end
          ST_CMD: begin
            phase <= ~phase;
            if (phase) begin
              if (bitCnt == CMD_LAST) begin
                state  <= ST_STAT;
                bitCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          ST_STAT: begin
            phase <= ~phase;
            if (phase) begin
              if (bitCnt == STAT_LAST) begin
                bitCnt <= '0;
                if (cfgAutoStop && hit) begin
                  state <= ST_IDLE;
                end else begin
                  state  <= ST_GAP;
                  gapCnt <= gapLoad;
                end
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          default: begin
            if (gapCnt == '0) begin
              state <= ST_CMD;
              phase <= 1'b0;
            end else begin
              gapCnt <= gapCnt - 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign inCmd        = (state == ST_CMD);
  assign busy         = (state != ST_IDLE);
  assign csN          = !shifting;
  assign sck          = shifting && phase;
  assign abortPending = abortPend;

  assert_abort_halts_R11: assert property (@(posedge clk) disable iff (!rstN)
    abortPend |=> !busy);

  assert_autostop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.compare && hit && cfgAutoStop) |=> !busy);

  assert_sck_in_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);

  assert_gap_min_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csN) && busy) |=> csN);

endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int STAT_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pollStrb_t            strb,
  input  logic                 inCmd,
  input  logic [CMD_BITS-1:0]  cfgOpcode,
  input  logic [STAT_BITS-1:0] cfgMask,
  input  logic [STAT_BITS-1:0] cfgMatch,
  input  logic                 cfgIntEn,
  input  logic                 clrStatusMatch,
  input  logic                 miso,
  output logic                 hit,
  output logic                 mosi,
  output logic                 matchFlag,
  output logic                 irq,
  output logic [STAT_BITS-1:0] statusWord
);

  localparam int NBYTES = STAT_BITS / 8;

  logic [CMD_BITS-1:0]  cmdSh;
  logic [STAT_BITS-1:0] inSh;
  logic [STAT_BITS-1:0] assembled;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byteOrder
    assign assembled[b*8 +: 8] = inSh[(NBYTES-1-b)*8 +: 8];
  end

  assign hit = (((assembled ^ cfgMatch) & cfgMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSh      <= '0;
      inSh       <= '0;
      statusWord <= '0;
      matchFlag  <= 1'b0;
    end else begin
      if (strb.loadCmd)
        cmdSh <= cfgOpcode;
      else if (strb.shiftCmd)
        cmdSh <= {cmdSh[CMD_BITS-2:0], 1'b0};
      if (strb.sampleBit)
        inSh <= {inSh[STAT_BITS-2:0], miso};
      if (strb.compare)
        statusWord <= assembled;
      if (strb.compare && hit)
        matchFlag <= 1'b1;
      else if (clrStatusMatch)
        matchFlag <= 1'b0;
    end
  end

  assign mosi = inCmd && cmdSh[CMD_BITS-1];
  assign irq  = matchFlag && cfgIntEn;

  assert_flag_on_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.compare && hit) |=> matchFlag);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrStatusMatch && !(strb.compare && hit)) |=> !matchFlag);

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.compare && !clrStatusMatch) |=> $stable(matchFlag));

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int STAT_BITS = 16,
  parameter int GAP_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           cfgMode,
  input  logic                 launch,
  input  logic [CMD_BITS-1:0]  cfgOpcode,
  input  logic [STAT_BITS-1:0] cfgMask,
  input  logic [STAT_BITS-1:0] cfgMatch,
  input  logic                 cfgIntEn,
  input  logic                 cfgAutoStop,
  input  logic [GAP_W-1:0]     cfgInterval,
  input  logic                 abortReq,
  input  logic                 clrStatusMatch,
  input  logic                 miso,
  output logic                 sck,
  output logic                 csN,
  output logic                 mosi,
  output logic                 busy,
  output logic                 abortPending,
  output logic                 matchFlag,
  output logic                 irq,
  output logic [STAT_BITS-1:0] statusWord
);

  pollStrb_t strb;
  logic      hit;
  logic      inCmd;

  fsp_ctrl #(
    .CMD_BITS (CMD_BITS),
    .STAT_BITS(STAT_BITS),
    .GAP_W    (GAP_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgMode     (cfgMode),
    .launch      (launch),
    .cfgAutoStop (cfgAutoStop),
    .cfgInterval (cfgInterval),
    .abortReq    (abortReq),
    .hit         (hit),
    .strb        (strb),
    .inCmd       (inCmd),
    .busy        (busy),
    .csN         (csN),
    .sck         (sck),
    .abortPending(abortPending)
  );

  fsp_datapath #(
    .CMD_BITS (CMD_BITS),
    .STAT_BITS(STAT_BITS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .inCmd         (inCmd),
    .cfgOpcode     (cfgOpcode),
    .cfgMask       (cfgMask),
    .cfgMatch      (cfgMatch),
    .cfgIntEn      (cfgIntEn),
    .clrStatusMatch(clrStatusMatch),
    .miso          (miso),
    .hit           (hit),
    .mosi          (mosi),
    .matchFlag     (matchFlag),
    .irq           (irq),
    .statusWord    (statusWord)
  );

endmodule

// File: tb/sim_flash_status_poller.sv
`timescale 1ns/1ps
module sim_flash_status_poller;

  localparam int FRAME = 2 * (8 + 16);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'b00;
  logic        launch = 1'b0;
  logic [7:0]  cfgOpcode = 8'h05;
  logic [15:0] cfgMask = 16'hFFFF;
  logic [15:0] cfgMatch = 16'h0000;
  logic        cfgIntEn = 1'b0;
  logic        cfgAutoStop = 1'b0;
  logic [15:0] cfgInterval = 16'd1;
  logic        abortReq = 1'b0;
  logic        clrStatusMatch = 1'b0;
  logic        miso = 1'b0;
  logic        sck, csN, mosi, busy, abortPending, matchFlag, irq;
  logic [15:0] statusWord;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] flashStatus = 16'h0000;
  logic [7:0]  capOp = 8'h00;

  always #5 clk = ~clk;

  flash_status_poller u0 (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .launch(launch),
    .cfgOpcode(cfgOpcode), .cfgMask(cfgMask), .cfgMatch(cfgMatch),
    .cfgIntEn(cfgIntEn), .cfgAutoStop(cfgAutoStop), .cfgInterval(cfgInterval),
    .abortReq(abortReq), .clrStatusMatch(clrStatusMatch), .miso(miso),
    .sck(sck), .csN(csN), .mosi(mosi), .busy(busy), .abortPending(abortPending),
    .matchFlag(matchFlag), .irq(irq), .statusWord(statusWord)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Flash device model: counts rising SCK edges seen while selected
  int flashCnt = 0;
  logic prevSck = 1'b0;
  always @(negedge clk) begin
    if (csN) begin
      flashCnt = 0;
    end else if (sck && !prevSck) begin
      if (flashCnt < 8) capOp = {capOp[6:0], mosi};
      flashCnt++;
    end
    prevSck = sck;
    if (!csN && flashCnt >= 8 && flashCnt < 24)
      miso = flashStatus[((flashCnt-8)/8)*8 + 7 - ((flashCnt-8)%8)];
    else
      miso = 1'b0;
  end

  // Behavioural reference: position within the poll period
  bit          mRun = 0;
  int          mPos = 0;
  int          mGap = 2;
  bit          mFlag = 0;
  bit          mAbort = 0;
  logic [15:0] mStatus = 16'h0;
  bit          modelLive = 0;

  always @(posedge clk) begin
    bit nFlag;
    bit hitM;
    if (!rstN) begin
      mRun = 0; mPos = 0; mFlag = 0; mAbort = 0; mStatus = 16'h0; mGap = 2;
    end else begin
      nFlag = mFlag;
      if (clrStatusMatch) nFlag = 0;
      if (mAbort) begin
        mRun = 0;
      end else if (!mRun) begin
        if (launch && cfgMode == 2'b10) begin mRun = 1; mPos = 0; end
      end else if (mPos == FRAME - 1) begin
        hitM = (((flashStatus ^ cfgMatch) & cfgMask) == 16'h0);
        mStatus = flashStatus;
        if (hitM) nFlag = 1;
        if (hitM && cfgAutoStop) mRun = 0;
        else begin
          mGap = (cfgInterval == 16'd0) ? 2 : 2 * int'(cfgInterval);
          mPos = FRAME;
        end
      end else begin
        mPos++;
        if (mPos == FRAME + mGap) mPos = 0;
      end
      mFlag = nFlag;
      mAbort = abortReq;
    end
  end

  // Every-cycle comparison of all outputs with the reference
  always @(negedge clk) begin
    bit inFrame;
    logic expMosi;
    if (modelLive) begin
      inFrame = mRun && (mPos < FRAME);
      expMosi = (mRun && mPos < 16) ? cfgOpcode[7 - mPos/2] : 1'b0;
      chk("R3", "csN", csN, !inFrame);
      chk("R3", "sck", sck, inFrame && (mPos % 2 == 1));
      chk("R3", "mosi", mosi, expMosi);
      chk("R8", "busy", busy, mRun);
      chk("R5", "matchFlag", matchFlag, mFlag);
      chk("R7", "irq", irq, mFlag && cfgIntEn);
      chk("R11", "abortPending", abortPending, mAbort);
      chk("R4", "statusWord", statusWord, mStatus);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic pulseLaunch();
    @(negedge clk) launch = 1'b1;
    @(negedge clk) launch = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk) clrStatusMatch = 1'b1;
    @(negedge clk) clrStatusMatch = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic waitGap();
    int n = 0;
    while (csN && n < 2000) begin @(negedge clk); n++; end
    while (!csN && n < 4000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int gapLen;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "csN", csN, 1'b1);
    chk("R1", "sck", sck, 1'b0);
    chk("R1", "mosi", mosi, 1'b0);
    chk("R1", "matchFlag", matchFlag, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    modelLive = 1;

    // R2: launch with a non-polling mode has no effect
    cfgMode = 2'b01;
    pulseLaunch();
    repeat (6) @(negedge clk);
    chk("R2", "busy after wrong mode", busy, 1'b0);
    chk("R2", "csN after wrong mode", csN, 1'b1);

    // R3 R4 R5 R7 R8: single matching poll with auto-stop
    cfgMode = 2'b10; cfgOpcode = 8'hB5; flashStatus = 16'hA53C;
    cfgMask = 16'hFFFF; cfgMatch = 16'hA53C; cfgAutoStop = 1'b1; cfgIntEn = 1'b1;
    pulseLaunch();
    @(negedge clk);
    pulseLaunch(); // R2: second launch while busy is ignored
    waitIdle();
    chk("R3", "opcode shifted out", capOp, 8'hB5);
    chk("R4", "statusWord byte order", statusWord, 16'hA53C);
    chk("R5", "flag after match", matchFlag, 1'b1);
    chk("R7", "irq with enable", irq, 1'b1);
    repeat (10) @(negedge clk);
    chk("R8", "stays idle after auto-stop", busy, 1'b0);

    // R6: clear flag
    pulseClear();
    chk("R6", "flag cleared", matchFlag, 1'b0);
    chk("R7", "irq follows flag", irq, 1'b0);

    // R7: match with interrupt disabled; R5: masked compare
    cfgIntEn = 1'b0; flashStatus = 16'h12F0; cfgMask = 16'h00F0; cfgMatch = 16'hFFF0;
    pulseLaunch();
    waitIdle();
    chk("R5", "masked match", matchFlag, 1'b1);
    chk("R7", "irq off when disabled", irq, 1'b0);
    cfgIntEn = 1'b1;
    @(negedge clk);
    chk("R7", "irq on enable", irq, 1'b1);
    pulseClear();

    // R9 R10: free-running poll, mismatch then match
    cfgAutoStop = 1'b0; cfgInterval = 16'd3;
    flashStatus = 16'h00FF; cfgMask = 16'h0F00; cfgMatch = 16'h0100;
    pulseLaunch();
    waitGap();
    gapLen = 0;
    while (csN && gapLen < 100) begin gapLen++; @(negedge clk); end
    chk("R10", "gap length interval 3", gapLen, 6);
    chk("R5", "no flag on mismatch", matchFlag, 1'b0);
    waitGap();
    flashStatus = 16'h01FF;
    waitGap();
    chk("R9", "flag on later match", matchFlag, 1'b1);
    chk("R9", "still polling", busy, 1'b1);
    pulseClear();
    waitGap();
    chk("R9", "flag set again", matchFlag, 1'b1);

    // R10: zero interval gives one SCK period
    cfgInterval = 16'd0;
    waitGap();
    waitGap();
    gapLen = 0;
    while (csN && gapLen < 100) begin gapLen++; @(negedge clk); end
    chk("R10", "gap length interval 0", gapLen, 2);

    // R11: abort mid-frame
    repeat (10) @(negedge clk);
    @(negedge clk) abortReq = 1'b1;
    @(negedge clk) abortReq = 1'b0;
    chk("R11", "abortPending set", abortPending, 1'b1);
    @(negedge clk);
    chk("R11", "abortPending clears", abortPending, 1'b0);
    chk("R11", "busy low after abort", busy, 1'b0);
    chk("R11", "csN high after abort", csN, 1'b1);
    repeat (60) @(negedge clk);
    chk("R11", "remains idle", busy, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule